// File: doc/BRIEF.md
# Per-Channel Calibration Constant Loader

This block holds a correction triple for every channel and amplifier range of a scanning front end and, on request, moves that triple into three correction DACs. The triple is an 8-bit coarse offset, a 12-bit fine offset and a 12-bit gain trim. Each scan slot starts a load with a one-cycle start pulse that carries the channel number and the range index picked by the autorange logic. The block then reads the local calibration memory and strobes the three DACs over a shared parallel data bus: coarse first, then fine, then gain. It raises a one-cycle done pulse, so that the correction is in place while the amplifier is still settling.

A host write port fills the memory between scans. Writes are ignored while the scan-active input is high. A start that arrives while a load is still running, or a start that names a range code outside the populated ranges, produces a one-cycle error pulse. Neither one changes the load in progress or the values the DACs receive. The memory can be addressed as channel times range count plus range, which is dense. It can also be addressed as the channel and a 3-bit range code placed side by side, which is simpler but leaves three codes unused per channel.

Top module: `cal_const_loader`

## Requirements
- R1: While rst_ni is low, coarse_ld_o, fine_ld_o, gain_ld_o, done_o and err_o are all low and dac_data_o is zero.
- R2: Every channel 0..63 paired with every range 0..4 has its own storage entry. A host write with wr_en_i high, scan_active_i low and a valid range replaces exactly that entry's triple.
- R3: A start accepted at clock edge k gives coarse_ld_o high for one cycle after edge k+1, fine_ld_o after edge k+2 and gain_ld_o after edge k+3. At most one strobe is high at any time.
- R4: The write word and the stored triple share one layout: coarse in bits 7:0, fine in bits 19:8 and gain in bits 31:20. While a strobe is high, dac_data_o carries that constant, and the 8-bit coarse value is zero-extended to 12 bits.
- R5: done_o is high for exactly the one cycle that follows the gain strobe.
- R6: A start sampled while a load is in its fetch, coarse, fine or gain cycle gives err_o high for the following cycle. The running load completes with its own values, and the rejected request starts no load.
- R7: A start whose range code is 5, 6 or 7 gives err_o high for the following cycle and produces no strobe and no done.
- R8: Host writes made while scan_active_i is high leave the memory unchanged.
- R9: A start sampled in the done cycle is accepted, so loads may run back to back every five cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle load request |
| ch_i | input | 6 | Channel of the load request |
| rng_i | input | 3 | Range code of the load request (0..4 valid) |
| scan_active_i | input | 1 | High while a scan runs; blocks host writes |
| wr_en_i | input | 1 | Host write enable |
| wr_ch_i | input | 6 | Host write channel |
| wr_rng_i | input | 3 | Host write range code |
| wr_data_i | input | 32 | Host write triple: gain 31:20, fine 19:8, coarse 7:0 |
| dac_data_o | output | 12 | Shared DAC data bus |
| coarse_ld_o | output | 1 | Coarse offset DAC load strobe |
| fine_ld_o | output | 1 | Fine offset DAC load strobe |
| gain_ld_o | output | 1 | Gain DAC load strobe |
| done_o | output | 1 | One-cycle load complete pulse |
| err_o | output | 1 | One-cycle sequencing error pulse |

## Verification
The bench fills all 320 entries with arithmetically distinct triples. It then loads every channel and range pair back to back and checks each strobe and its data in the cycle it must appear. A wrong address multiply or a swapped field would therefore show up as a mismatched constant on some pair. A start is injected during a running load. A design that restarts or re-latches the address would then put another channel's coarse or fine value on the bus, or run a second sequence. Reserved range codes must produce an error and no strobes, which catches a design that loads an unused memory word. A write issued during a scan must leave the entry unchanged on its next load, which catches a write path that ignores scan_active_i.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int COARSE_W = 8;
  localparam int FINE_W   = 12;
  localparam int GAIN_W   = 12;
  localparam int ENTRY_W  = COARSE_W + FINE_W + GAIN_W;
  localparam int DAC_W    = (GAIN_W > FINE_W) ?
                            ((GAIN_W > COARSE_W) ? GAIN_W : COARSE_W) :
                            ((FINE_W > COARSE_W) ? FINE_W : COARSE_W);

  typedef struct packed {
    logic [GAIN_W-1:0]   gain;
    logic [FINE_W-1:0]   fine;
    logic [COARSE_W-1:0] coarse;
  } cal_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_COARSE, ST_FINE, ST_GAIN, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/cal_addr_gen.sv
module cal_addr_gen #(
  parameter int N_CH    = 64,
  parameter int N_RANGE = 5,
  parameter int CH_W    = 6,
  parameter int RNG_W   = 3,
  parameter int ADDR_W  = 9,
  parameter bit PACKED  = 1'b0
) (
  input  logic [CH_W-1:0]   ch_i,
  input  logic [RNG_W-1:0]  rng_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  generate
    if (PACKED) begin : g_packed
      assign addr_o = {ch_i, rng_i};
    end else begin : g_linear
      assign addr_o = ADDR_W'(ch_i) * ADDR_W'(N_RANGE) + ADDR_W'(rng_i);
    end
  endgenerate

  assign valid_o = ({1'b0, rng_i} < (RNG_W+1)'(N_RANGE)) &&
                   ({1'b0, ch_i}  < (CH_W+1)'(N_CH));
endmodule

// File: rtl/cal_mem.sv
module cal_mem
  import cal_pkg::*;
#(
  parameter int DEPTH  = 320,
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  cal_entry_t        wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output cal_entry_t        rd_data_o
);
  cal_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  cal_entry_t        rd_data_i,
  output logic [DAC_W-1:0]  dac_data_o,
  output logic              coarse_ld_o,
  output logic              fine_ld_o,
  output logic              gain_ld_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic busy, accept;

  // done cycle counts as free so loads can chain
  assign busy   = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign accept = start_i && !busy && req_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: state_d = accept ? ST_FETCH : ST_IDLE;
      ST_FETCH:         state_d = ST_COARSE;
      ST_COARSE:        state_d = ST_FINE;
      ST_FINE:          state_d = ST_GAIN;
      ST_GAIN:          state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) addr_q <= req_addr_i;
      err_o <= start_i && (busy || !req_valid_i);
    end
  end

  assign rd_en_o     = (state_q == ST_FETCH);
  assign rd_addr_o   = addr_q;
  assign coarse_ld_o = (state_q == ST_COARSE);
  assign fine_ld_o   = (state_q == ST_FINE);
  assign gain_ld_o   = (state_q == ST_GAIN);
  assign done_o      = (state_q == ST_DONE);

  always_comb begin
    unique case (state_q)
      ST_COARSE: dac_data_o = DAC_W'(rd_data_i.coarse);
      ST_FINE:   dac_data_o = DAC_W'(rd_data_i.fine);
      ST_GAIN:   dac_data_o = DAC_W'(rd_data_i.gain);
      default:   dac_data_o = '0;
    endcase
  end

  // R3
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({coarse_ld_o, fine_ld_o, gain_ld_o}));
  // R3
  coarse_then_fine_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse_ld_o |=> fine_ld_o);
  // R3
  fine_then_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_ld_o |=> gain_ld_o);
  // R5
  gain_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_ld_o |=> (done_o && !gain_ld_o));
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/cal_const_loader.sv
module cal_const_loader
  import cal_pkg::*;
#(
  parameter int N_CH        = 64,
  parameter int N_RANGE     = 5,
  parameter bit ADDR_PACKED = 1'b0,
  localparam int CH_W       = $clog2(N_CH),
  localparam int RNG_W      = $clog2(N_RANGE)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CH_W-1:0]    ch_i,
  input  logic [RNG_W-1:0]   rng_i,
  input  logic               scan_active_i,
  input  logic               wr_en_i,
  input  logic [CH_W-1:0]    wr_ch_i,
  input  logic [RNG_W-1:0]   wr_rng_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  output logic [DAC_W-1:0]   dac_data_o,
  output logic               coarse_ld_o,
  output logic               fine_ld_o,
  output logic               gain_ld_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int LIN_DEPTH = N_CH * N_RANGE;
  localparam int ADDR_W    = ADDR_PACKED ? (CH_W + RNG_W) : $clog2(LIN_DEPTH);
  localparam int DEPTH     = ADDR_PACKED ? (N_CH << RNG_W) : LIN_DEPTH;

  logic [ADDR_W-1:0] req_addr, wr_addr, rd_addr;
  logic req_valid, wr_valid, rd_en;
  cal_entry_t rd_data;

  cal_addr_gen #(
    .N_CH(N_CH), .N_RANGE(N_RANGE), .CH_W(CH_W), .RNG_W(RNG_W),
    .ADDR_W(ADDR_W), .PACKED(ADDR_PACKED)
  ) u_req_addr (
    .ch_i(ch_i), .rng_i(rng_i), .addr_o(req_addr), .valid_o(req_valid)
  );

  cal_addr_gen #(
    .N_CH(N_CH), .N_RANGE(N_RANGE), .CH_W(CH_W), .RNG_W(RNG_W),
    .ADDR_W(ADDR_W), .PACKED(ADDR_PACKED)
  ) u_wr_addr (
    .ch_i(wr_ch_i), .rng_i(wr_rng_i), .addr_o(wr_addr), .valid_o(wr_valid)
  );

  cal_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk_i(clk_i),
    .wr_en_i(wr_en_i && wr_valid && !scan_active_i),
    .wr_addr_i(wr_addr),
    .wr_data_i(cal_entry_t'(wr_data_i)),
    .rd_en_i(rd_en),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  cal_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .dac_data_o(dac_data_o), .coarse_ld_o(coarse_ld_o),
    .fine_ld_o(fine_ld_o), .gain_ld_o(gain_ld_o),
    .done_o(done_o), .err_o(err_o)
  );
endmodule

// File: tb/cal_const_loader_tb_top.sv
`timescale 1ns/1ps
module cal_const_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  ch = '0;
  logic [2:0]  rng = '0;
  logic        scan = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_ch = '0;
  logic [2:0]  wr_rng = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] dac_data;
  logic        c_ld, f_ld, g_ld, done, err;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cal_const_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ch_i(ch), .rng_i(rng),
    .scan_active_i(scan), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_rng_i(wr_rng), .wr_data_i(wr_data), .dac_data_o(dac_data),
    .coarse_ld_o(c_ld), .fine_ld_o(f_ld), .gain_ld_o(g_ld),
    .done_o(done), .err_o(err)
  );

  function automatic int exp_coarse(int c, int r);
    return ((c * 5 + r) * 7 + 3) % 256;
  endfunction
  function automatic int exp_fine(int c, int r);
    return (c * 37 + r * 911 + 5) % 4096;
  endfunction
  function automatic int exp_gain(int c, int r);
    return (c * 101 + r * 13 + 1) % 4096;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_quiet(string tag);
    check({tag, " strobes"}, {c_ld, f_ld, g_ld}, 0);
    check({tag, " done"}, done, 0);
  endtask

  // caller is at a negedge; returns at the negedge of the done cycle
  task automatic load_check(int c, int r, int co, int fi, int ga, bit inject);
    start = 1'b1; ch = 6'(c); rng = 3'(r);
    @(negedge clk);                        // fetch cycle
    if (inject) begin ch = 6'((c + 1) % 64); rng = 3'd0; end
    else start = 1'b0;
    check("R3 fetch no strobe", {c_ld, f_ld, g_ld}, 0);
    check("R6 no err on accept", err, 0);
    @(negedge clk);
    start = 1'b0;
    check("R3 coarse strobe", {c_ld, f_ld, g_ld}, 3'b100);
    check("R4 coarse data", dac_data, co);
    check("R6 err on busy start", err, inject);
    @(negedge clk);
    check("R3 fine strobe", {c_ld, f_ld, g_ld}, 3'b010);
    check("R4 fine data", dac_data, fi);
    @(negedge clk);
    check("R3 gain strobe", {c_ld, f_ld, g_ld}, 3'b001);
    check("R4 gain data", dac_data, ga);
    check("R5 no early done", done, 0);
    @(negedge clk);
    check("R5 done pulse", done, 1);
    check("R5 strobes off in done", {c_ld, f_ld, g_ld}, 0);
  endtask

  task automatic host_write(int c, int r, logic [31:0] d);
    wr_en = 1'b1; wr_ch = 6'(c); wr_rng = 3'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] pack(int c, int r);
    return {12'(exp_gain(c, r)), 12'(exp_fine(c, r)), 8'(exp_coarse(c, r))};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 coarse_ld", c_ld, 0);
    check("R1 fine_ld", f_ld, 0);
    check("R1 gain_ld", g_ld, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 dac_data", dac_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 fill every entry
    for (int c = 0; c < 64; c++)
      for (int r = 0; r < 5; r++) host_write(c, r, pack(c, r));

    // R8 write during scan must be dropped
    scan = 1'b1;
    host_write(3, 2, 32'hFFFF_FFFF);
    host_write(63, 4, 32'h0000_0000);

    // R2 R4 R9 back-to-back over every channel and range
    for (int c = 0; c < 64; c++)
      for (int r = 0; r < 5; r++)
        load_check(c, r, exp_coarse(c, r), exp_fine(c, r), exp_gain(c, r), 1'b0);
    @(negedge clk);
    check_quiet("R9 idle after chain");

    // R8 entries written during scan still hold original values
    load_check(3, 2, exp_coarse(3, 2), exp_fine(3, 2), exp_gain(3, 2), 1'b0);
    load_check(63, 4, exp_coarse(63, 4), exp_fine(63, 4), exp_gain(63, 4), 1'b0);
    @(negedge clk);

    // R6 start during load: error, values intact, no second run
    load_check(10, 3, exp_coarse(10, 3), exp_fine(10, 3), exp_gain(10, 3), 1'b1);
    @(negedge clk);
    check_quiet("R6 no extra load a");
    @(negedge clk);
    check_quiet("R6 no extra load b");
    @(negedge clk);
    check_quiet("R6 no extra load c");

    // R7 reserved range codes
    for (int r = 5; r < 8; r++) begin
      start = 1'b1; ch = 6'd7; rng = 3'(r);
      @(negedge clk);
      start = 1'b0;
      check("R7 err on reserved range", err, 1);
      for (int k = 0; k < 5; k++) begin
        check_quiet("R7 no load");
        @(negedge clk);
      end
      check("R7 err clears", err, 0);
    end

    // R2 rewrite one entry after the scan, neighbours untouched
    scan = 1'b0;
    host_write(20, 1, {12'd4095, 12'd0, 8'd255});
    scan = 1'b1;
    load_check(20, 1, 255, 0, 4095, 1'b0);
    load_check(20, 2, exp_coarse(20, 2), exp_fine(20, 2), exp_gain(20, 2), 1'b0);
    load_check(20, 0, exp_coarse(20, 0), exp_fine(20, 0), exp_gain(20, 0), 1'b0);
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule